// File: doc/BRIEF.md
# DMA channel address and count generator

This block is the address and transfer-count engine of a single DMA channel laid out in the classic PC style. Software programs it one byte at a time. It takes an 8-bit page, a 16-bit address, a 16-bit count and a mode byte. Address and count values go in as two bytes through a shared low/high byte pointer. Each write loads the base copy and the current copy of a register in the same cycle. The channel then runs on a transfer strobe. Each accepted strobe puts out a 24-bit memory address and steps the current address and count.

Two data widths are supported. A byte channel forms the memory address directly from the page and the current address. A word channel counts 16-bit words: it shifts the current address up one bit, drives bit 0 to zero and drops the page LSB. Address stepping never carries into the page. Terminal count is flagged on the transfer that takes the count from zero to all-ones. At terminal count the channel does one of two things. With autoinitialize set, it reloads its current registers from the base copies. Otherwise it goes idle and ignores strobes until its count is rewritten.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset `mem_addr` is 0, `cur_count` is 0, `idle` is 1, the byte pointer selects the low byte, and the mode is byte channel, incrementing, no autoinitialize.
- R2: Address writes (`wr_sel`=0) and count writes (`wr_sel`=1) fill the low byte first, then the high byte, and the shared pointer toggles on each of them. Page writes (`wr_sel`=2) and mode writes (`wr_sel`=3) leave the pointer alone. A pulse on `ptr_clr` returns it to the low byte.
- R3: A register write loads the base copy and the current copy of that byte in the same cycle.
- R4: With the mode's word bit (bit 2) clear, `mem_addr` = {current page[7:0], current address[15:0]}.
- R5: With the word bit set, `mem_addr` = {current page[7:1], current address[15:0], 1'b0}, so the page LSB has no effect.
- R6: Each accepted transfer changes the current address by exactly 1. It decrements when mode bit 0 is 1 and increments when it is 0.
- R7: A transfer never changes the page. The address wraps within 16 bits: FFFF+1 gives 0000 and 0000-1 gives FFFF.
- R8: Each accepted transfer decrements `cur_count` by 1. `tc` is high, combinationally, in the cycle of an accepted transfer while `cur_count` is 0. A programmed count N therefore moves N+1 units.
- R9: With mode bit 1 (autoinitialize) set, terminal count restores the current page, address and count from their base copies on the next edge, and `idle` stays 0.
- R10: Without autoinitialize, terminal count sets `idle`. While `idle` is 1, strobes change nothing and `tc` stays 0. Writing the count high byte clears `idle`.
- R11: A transfer strobe in the same cycle as a register write is dropped. The write takes effect, and the address and count do not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 address, 1 count, 2 page, 3 mode |
| wr_data | input | 8 | Write byte; for mode: bit0 down, bit1 autoinit, bit2 word |
| ptr_clr | input | 1 | Reset the low/high byte pointer to low |
| xfer | input | 1 | Transfer strobe, one unit per cycle high |
| mem_addr | output | 24 | Memory address for the current transfer |
| cur_count | output | 16 | Current remaining count |
| tc | output | 1 | Terminal count, high on the final accepted transfer |
| idle | output | 1 | Channel stopped; strobes ignored |

## Verification
The assertions in the RTL check the per-transfer step rules on every cycle. The address moves by one in the selected direction, the count drops by one and the page holds. They also check that an autoinitialize restore reproduces the base copies and that an idle channel keeps its state. The bench's scenarios are needed for the effects that depend on a sequence. These are byte-pointer ordering and clearing, the word-mode bit mapping with an odd page, 16-bit wrap without page carry, and the exact transfer on which `tc` fires. A behavioural model in the bench, compared every cycle, covers a long mixed stimulus stream.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

   typedef enum logic [1:0] {
      SEL_ADDR  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_PAGE  = 2'd2,
      SEL_MODE  = 2'd3
   } reg_sel_e;

   // bit2 word channel, bit1 autoinitialize, bit0 decrement
   typedef struct packed {
      logic word;
      logic autoinit;
      logic down;
   } mode_t;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/dma_ag_byteptr.sv
module dma_ag_byteptr #(
   parameter int NB = 2,
   localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [PW-1:0] ptr,
   output logic          last
);

   initial begin
      if (NB < 1) $error("dma_ag_byteptr: NB must be at least 1");
   end

   assign last = (ptr == PW'(NB - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (clr) ptr <= '0;
      else if (adv) ptr <= last ? '0 : ptr + 1'b1;
   end

endmodule

// File: rtl/dma_ag_regpair.sv
module dma_ag_regpair #(
   parameter int W = 16,
   localparam int NB = W / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] lane_we,
   input  logic [7:0]    wbyte,
   input  logic          restore,
   input  logic          step,
   input  logic          down,
   output logic [W-1:0]  base_q,
   output logic [W-1:0]  cur_q
);

   logic [W-1:0] base_n, cur_n;

   initial begin
      if (W < 8 || (W % 8) != 0) $error("dma_ag_regpair: W must be a multiple of 8");
   end

   always_comb begin
      base_n = base_q;
      cur_n  = cur_q;
      if (restore)   cur_n = base_q;
      else if (step) cur_n = down ? cur_q - W'(1) : cur_q + W'(1);
      for (int i = 0; i < NB; i++) begin
         if (lane_we[i]) begin
            base_n[i*8 +: 8] = wbyte;
            cur_n[i*8 +: 8]  = wbyte;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else begin
         base_q <= base_n;
         cur_q  <= cur_n;
      end
   end

endmodule

// File: rtl/dma_ag_addrmap.sv
module dma_ag_addrmap #(
   parameter int REG_W        = 16,
   parameter int PAGE_W       = 8,
   parameter bit WORD_SUPPORT = 1'b1
) (
   input  logic [PAGE_W-1:0]       page,
   input  logic [REG_W-1:0]        addr,
   input  logic                    word,
   output logic [PAGE_W+REG_W-1:0] maddr
);

   initial begin
      if (PAGE_W < 2) $error("dma_ag_addrmap: PAGE_W must be at least 2");
   end

   if (WORD_SUPPORT) begin : g_word
      assign maddr = word ? {page[PAGE_W-1:1], addr, 1'b0} : {page, addr};
   end else begin : g_byte
      logic unused_word;
      assign unused_word = word;
      assign maddr = {page, addr};
   end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dma_ag_pkg::*;
#(
   parameter int REG_W        = 16,
   parameter int PAGE_W       = 8,
   parameter bit WORD_SUPPORT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [1:0]              wr_sel,
   input  logic [7:0]              wr_data,
   input  logic                    ptr_clr,
   input  logic                    xfer,
   output logic [PAGE_W+REG_W-1:0] mem_addr,
   output logic [REG_W-1:0]        cur_count,
   output logic                    tc,
   output logic                    idle
);

   localparam int NB = REG_W / BYTE_W;
   localparam int PW = (NB > 1) ? $clog2(NB) : 1;

   initial begin
      if (REG_W < BYTE_W || (REG_W % BYTE_W) != 0)
         $error("dma_addr_gen: REG_W must be a multiple of 8");
      if (PAGE_W != BYTE_W)
         $error("dma_addr_gen: PAGE_W must equal one write byte");
   end

   reg_sel_e        sel;
   logic            wr_addr, wr_cnt, wr_page, wr_mode;
   logic [PW-1:0]   ptr;
   logic            ptr_last;
   logic [NB-1:0]   addr_we, cnt_we;
   mode_t           mode_q;
   logic            acc, restore;
   logic [REG_W-1:0]  addr_base, addr_cur, cnt_base, cnt_cur;
   logic [PAGE_W-1:0] page_base, page_cur;

   assign sel     = reg_sel_e'(wr_sel);
   assign wr_addr = wr_en && (sel == SEL_ADDR);
   assign wr_cnt  = wr_en && (sel == SEL_COUNT);
   assign wr_page = wr_en && (sel == SEL_PAGE);
   assign wr_mode = wr_en && (sel == SEL_MODE);

   dma_ag_byteptr #(.NB(NB)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (ptr_clr),
      .adv  (wr_addr || wr_cnt),
      .ptr  (ptr),
      .last (ptr_last)
   );

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign addr_we[i] = wr_addr && (ptr == PW'(i));
      assign cnt_we[i]  = wr_cnt  && (ptr == PW'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= '0;
      else if (wr_mode) mode_q <= mode_t'(wr_data[2:0]);
   end

   // transfer accepted only on a running channel with no write pending
   assign acc     = xfer && !idle && !wr_en;
   assign tc      = acc && (cnt_cur == '0);
   assign restore = tc && mode_q.autoinit;

   always_ff @(posedge clk) begin
      if (!rst_n)                        idle <= 1'b1;
      else if (wr_cnt && ptr_last)       idle <= 1'b0;
      else if (tc && !mode_q.autoinit)   idle <= 1'b1;
   end

   dma_ag_regpair #(.W(REG_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .lane_we(addr_we),
      .wbyte  (wr_data),
      .restore(restore),
      .step   (acc),
      .down   (mode_q.down),
      .base_q (addr_base),
      .cur_q  (addr_cur)
   );

   dma_ag_regpair #(.W(REG_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .lane_we(cnt_we),
      .wbyte  (wr_data),
      .restore(restore),
      .step   (acc),
      .down   (1'b1),
      .base_q (cnt_base),
      .cur_q  (cnt_cur)
   );

   dma_ag_regpair #(.W(PAGE_W)) u_page (
      .clk    (clk),
      .rst_n  (rst_n),
      .lane_we(wr_page),
      .wbyte  (wr_data),
      .restore(restore),
      .step   (1'b0),
      .down   (1'b0),
      .base_q (page_base),
      .cur_q  (page_cur)
   );

   dma_ag_addrmap #(
      .REG_W       (REG_W),
      .PAGE_W      (PAGE_W),
      .WORD_SUPPORT(WORD_SUPPORT)
   ) u_map (
      .page (page_cur),
      .addr (addr_cur),
      .word (mode_q.word),
      .maddr(mem_addr)
   );

   assign cur_count = cnt_cur;

   // R6: one step per accepted transfer, in the programmed direction
   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !restore) |=> (addr_cur == ($past(mode_q.down) ? $past(addr_cur) - REG_W'(1)
                                                              : $past(addr_cur) + REG_W'(1))));

   // R7: stepping never reaches the page
   p_page_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !restore) |=> $stable(page_cur));

   // R8: count drops by one per accepted transfer
   p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !restore) |=> (cnt_cur == $past(cnt_cur) - REG_W'(1)));

   // R9: autoinitialize brings back all three base copies
   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restore |=> (addr_cur == $past(addr_base) && cnt_cur == $past(cnt_base)
                   && page_cur == $past(page_base) && !idle));

   // R10: terminal count without autoinitialize stops the channel
   p_tc_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !mode_q.autoinit) |=> idle);

   // R10: an idle channel holds its state until rewritten
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !wr_en) |=> ($stable(addr_cur) && $stable(cnt_cur) && idle));

   // R11: a mode or page write drops a coincident strobe
   p_wr_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_page || wr_mode) |=> ($stable(addr_cur) && $stable(cnt_cur)));

endmodule

// File: tb/tb_dma_addr_gen.sv
`timescale 1ns/1ps
module tb_dma_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [7:0]  wr_data;
   logic        ptr_clr;
   logic        xfer;
   logic [23:0] mem_addr;
   logic [15:0] cur_count;
   logic        tc;
   logic        idle;

   always #2 clk = ~clk;

   dma_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ptr_clr(ptr_clr), .xfer(xfer),
      .mem_addr(mem_addr), .cur_count(cur_count), .tc(tc), .idle(idle)
   );

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_ba, m_ca, m_bc, m_cc, m_bp, m_cp;
   bit m_ptr, m_idle, m_down, m_auto, m_word;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_addr();
      logic [7:0]  p;
      logic [15:0] a;
      p = 8'(m_cp);
      a = 16'(m_ca);
      if (m_word) return {p[7:1], a, 1'b0};
      return {p, a};
   endfunction

   task automatic model_step(input bit we, input logic [1:0] sel,
                             input logic [7:0] d, input bit clr, input bit x);
      bit acc;
      bit ttc;
      acc = x && !m_idle && !we;
      ttc = acc && (m_cc == 0);
      if (we) begin
         case (sel)
            2'd0: begin
               if (m_ptr) begin m_ba = (m_ba & 'h00FF) | (int'(d) << 8); m_ca = (m_ca & 'h00FF) | (int'(d) << 8); end
               else       begin m_ba = (m_ba & 'hFF00) | int'(d);        m_ca = (m_ca & 'hFF00) | int'(d); end
            end
            2'd1: begin
               if (m_ptr) begin m_bc = (m_bc & 'h00FF) | (int'(d) << 8); m_cc = (m_cc & 'h00FF) | (int'(d) << 8); m_idle = 1'b0; end
               else       begin m_bc = (m_bc & 'hFF00) | int'(d);        m_cc = (m_cc & 'hFF00) | int'(d); end
            end
            2'd2: begin m_bp = int'(d); m_cp = int'(d); end
            default: begin m_down = d[0]; m_auto = d[1]; m_word = d[2]; end
         endcase
      end
      if (clr) m_ptr = 1'b0;
      else if (we && (sel == 2'd0 || sel == 2'd1)) m_ptr = !m_ptr;
      if (acc) begin
         if (ttc && m_auto) begin
            m_ca = m_ba; m_cc = m_bc; m_cp = m_bp;
         end else begin
            m_ca = m_down ? ((m_ca + 'hFFFF) & 'hFFFF) : ((m_ca + 1) & 'hFFFF);
            m_cc = (m_cc + 'hFFFF) & 'hFFFF;
            if (ttc) m_idle = 1'b1;
         end
      end
   endtask

   // one clock: compare registered state, drive inputs, compare tc, advance model
   task automatic cyc(input bit we, input logic [1:0] sel, input logic [7:0] d,
                      input bit clr, input bit x);
      bit etc;
      @(negedge clk);
      chk(m_word ? "R5" : "R4", "mem_addr", 32'(mem_addr), 32'(exp_addr()));
      chk("R8", "cur_count", 32'(cur_count), 32'(m_cc));
      chk("R10", "idle", 32'(idle), 32'(m_idle));
      wr_en = we; wr_sel = sel; wr_data = d; ptr_clr = clr; xfer = x;
      #1;
      etc = x && !m_idle && !we && (m_cc == 0);
      chk("R8", "tc", 32'(tc), 32'(etc));
      model_step(we, sel, d, clr, x);
   endtask

   task automatic nop();                               cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0); endtask
   task automatic xf();                                cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1); endtask
   task automatic pclr();                              cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0); endtask
   task automatic wr(input logic [1:0] s, input logic [7:0] d); cyc(1'b1, s, d, 1'b0, 1'b0); endtask
   task automatic wr16(input logic [1:0] s, input logic [15:0] v);
      wr(s, v[7:0]);
      wr(s, v[15:8]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00; ptr_clr = 1'b0; xfer = 1'b0;
      m_ba = 0; m_ca = 0; m_bc = 0; m_cc = 0; m_bp = 0; m_cp = 0;
      m_ptr = 1'b0; m_idle = 1'b1; m_down = 1'b0; m_auto = 1'b0; m_word = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1", "mem_addr", 32'(mem_addr), 32'h0);
      chk("R1", "cur_count", 32'(cur_count), 32'h0);
      chk("R1", "idle", 32'(idle), 32'h1);
      xf(); nop();
      chk("R10", "strobe at reset ignored", 32'(cur_count), 32'h0);

      // byte channel, increment, no autoinit, count 3 -> four transfers
      wr(2'd3, 8'h00); wr(2'd2, 8'h12); wr16(2'd0, 16'h34FE); wr16(2'd1, 16'h0003); nop();
      chk("R3", "programmed address", 32'(mem_addr), 32'h1234FE);
      chk("R10", "idle cleared by count high", 32'(idle), 32'h0);
      xf(); xf(); xf();
      cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
      chk("R8", "tc on fourth transfer", 32'(tc), 32'h1);
      nop();
      chk("R6", "four increments", 32'(mem_addr), 32'h123502);
      chk("R8", "count wrapped", 32'(cur_count), 32'hFFFF);
      chk("R10", "idle after tc", 32'(idle), 32'h1);
      xf(); xf(); nop();
      chk("R10", "strobes ignored when idle", 32'(mem_addr), 32'h123502);

      // R2: pointer clear and non-toggling page write
      wr(2'd0, 8'hAA); pclr(); wr(2'd0, 8'h55); wr(2'd2, 8'h12); wr(2'd0, 8'h66); nop();
      chk("R2", "byte pointer order", 32'(mem_addr), 32'h126655);

      // R7: increment wrap without page carry
      wr16(2'd0, 16'hFFFF); wr(2'd2, 8'h07); wr16(2'd1, 16'h0002); xf(); nop();
      chk("R7", "inc wrap keeps page", 32'(mem_addr), 32'h070000);
      wr(2'd3, 8'h01); xf(); nop();
      chk("R7", "dec wrap keeps page", 32'(mem_addr), 32'h07FFFF);
      chk("R8", "count after two", 32'(cur_count), 32'h0);

      // R5/R9: word channel, decrement, autoinit, odd page
      wr(2'd3, 8'h07); wr(2'd2, 8'h35); wr16(2'd0, 16'h0001); wr16(2'd1, 16'h0001); nop();
      chk("R5", "word shift drops page lsb", 32'(mem_addr), 32'h340002);
      xf(); nop();
      chk("R5", "word address after step", 32'(mem_addr), 32'h340000);
      xf(); nop();
      chk("R9", "address restored", 32'(mem_addr), 32'h340002);
      chk("R9", "count restored", 32'(cur_count), 32'h1);
      chk("R9", "still running", 32'(idle), 32'h0);
      xf(); nop();

      // R11: write with strobe drops the strobe
      cyc(1'b1, 2'd3, 8'h07, 1'b0, 1'b1); nop();
      chk("R11", "count held", 32'(cur_count), 32'h0);
      chk("R11", "address held", 32'(mem_addr), 32'h340000);

      // mixed stream checked cycle by cycle against the model
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 8)       wr(2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
         else if (r < 10) pclr();
         else if (r < 12) cyc(1'b1, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 3)), 1'b0, 1'b1);
         else if (r < 80) xf();
         else             nop();
      end
      nop();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule